// File: doc/BRIEF.md
# PLL Lock Detector

This block watches the charge-pump drive of a frequency synthesiser and reports whether the loop is settled. It runs on the crystal clock. In every crystal cycle it sees the pump-up and pump-down requests. At the start of each reference period it also gets a one-cycle tick. The block measures each pump pulse in crystal cycles. A pulse longer than the allowed limit marks the current reference period as dirty.

The lock flag has asymmetric hysteresis. One over-wide pulse drops the flag on the next clock edge. Raising it needs an unbroken run of clean reference periods, eight by default. The flag is meant to be copied into a status word that a controller reads.

Top module: `pll_lock_detect`

## Requirements
- R1: A synchronous active-high reset clears the lock flag, the clean-period run and the period-arming state. After reset the flag stays low until a full clean run has been seen.
- R2: Pulse width is counted in crystal cycles in which pump_up or pump_dn (or both) is high. A one-cycle request is narrow, and so are one-cycle requests separated by an idle cycle. An up request followed directly by a down request forms one two-cycle pulse.
- R3: A pulse lasting WIDTH_LIMIT+1 consecutive cycles (2 by default) is wide. The lock flag reads low on the clock edge that ends the second active cycle, without waiting for the reference tick.
- R4: The flag rises on the clock edge of the tick that closes the GOOD_RUN-th (8th) consecutive clean period.
- R5: A wide pulse anywhere in a period sets the clean-run count back to zero. A run that has reached seven is therefore lost.
- R6: The first tick after reset only opens a period. From reset, the flag rises on the ninth tick when every pulse is narrow.
- R7: A wide pulse still active in the tick cycle makes the newly opened period dirty as well. The flag then rises on the ninth tick after that tick.
- R8: The flag rises only on a tick edge and never inside a period. Other than by reset, it falls only after a wide pulse.
- R9: Once set, the flag stays high across any number of further clean periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_tick | input | 1 | One-cycle mark at each reference period boundary |
| pump_up | input | 1 | Charge-pump source request |
| pump_dn | input | 1 | Charge-pump sink request |
| lock_flag | output | 1 | High while the loop is judged locked |

## Verification
A run count that is off by one shows up as a flag that rises one reference tick early or late. The bench checks the flag right after every tick, so such an error appears within one reference period. A width meter that misses saturation or does not merge up and down requests shows up on the edge right after the second active cycle. At that point the flag either fails to drop or drops for a narrow pattern. Faults in the arming or tick-overlap handling move the rise by exactly one tick, and the directed cases aim at exactly that tick.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;

    localparam int unsigned WIDTH_LIMIT_DEF = 1;
    localparam int unsigned GOOD_RUN_DEF    = 8;

    typedef enum logic [1:0] {
        VERDICT_NONE  = 2'd0,
        VERDICT_CLEAN = 2'd1,
        VERDICT_DIRTY = 2'd2
    } verdict_e;

    typedef struct packed {
        logic     close;
        verdict_e verdict;
    } period_rep_t;

    function automatic verdict_e judge(input logic close, input logic dirty);
        if (!close)
            return VERDICT_NONE;
        return dirty ? VERDICT_DIRTY : VERDICT_CLEAN;
    endfunction

endpackage

// File: rtl/pld_width_meter.sv
module pld_width_meter
    import pll_lock_pkg::*;
#(
    parameter int unsigned WIDTH_LIMIT = WIDTH_LIMIT_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic pump_up,
    input  logic pump_dn,
    output logic wide_hit
);
    localparam int unsigned CW = $clog2(WIDTH_LIMIT + 2);
    localparam logic [CW-1:0] LIMIT_C = CW'(WIDTH_LIMIT);

    logic          active;
    logic [CW-1:0] run_q;

    assign active = pump_up | pump_dn;

    always_ff @(posedge clk) begin
        if (rst)
            run_q <= '0;
        else if (!active)
            run_q <= '0;
        else if (run_q != LIMIT_C)
            run_q <= run_q + 1'b1;
    end

    // Current active cycle is the (WIDTH_LIMIT+1)-th in a row
    assign wide_hit = active && (run_q == LIMIT_C);

endmodule

// File: rtl/pld_period_judge.sv
module pld_period_judge
    import pll_lock_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ref_tick,
    input  logic        wide_hit,
    output period_rep_t rep
);
    logic armed_q;
    logic dirty_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            dirty_q <= 1'b0;
        end else begin
            if (ref_tick)
                armed_q <= 1'b1;
            // A wide pulse in the tick cycle also taints the new period
            if (wide_hit)
                dirty_q <= 1'b1;
            else if (ref_tick)
                dirty_q <= 1'b0;
        end
    end

    always_comb begin
        rep.close   = ref_tick && armed_q;
        rep.verdict = judge(rep.close, dirty_q || wide_hit);
    end

endmodule

// File: rtl/pld_run_counter.sv
module pld_run_counter
    import pll_lock_pkg::*;
#(
    parameter int unsigned GOOD_RUN = GOOD_RUN_DEF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wide_hit,
    input  period_rep_t rep,
    output logic        reach
);
    localparam int unsigned RW = $clog2(GOOD_RUN + 1);
    localparam logic [RW-1:0] FULL_C = RW'(GOOD_RUN);
    localparam logic [RW-1:0] LAST_C = RW'(GOOD_RUN - 1);

    logic [RW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (wide_hit)
            cnt_q <= '0;
        else if (rep.close) begin
            if (rep.verdict == VERDICT_DIRTY)
                cnt_q <= '0;
            else if (cnt_q != FULL_C)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign reach = rep.close && (rep.verdict == VERDICT_CLEAN) && (cnt_q == LAST_C);

endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect
    import pll_lock_pkg::*;
#(
    parameter int unsigned WIDTH_LIMIT = WIDTH_LIMIT_DEF,
    parameter int unsigned GOOD_RUN    = GOOD_RUN_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_tick,
    input  logic pump_up,
    input  logic pump_dn,
    output logic lock_flag
);
    logic        wide_hit;
    logic        reach;
    period_rep_t rep;
    logic        flag_q;

    pld_width_meter #(.WIDTH_LIMIT(WIDTH_LIMIT)) meter_i (
        .clk      (clk),
        .rst      (rst),
        .pump_up  (pump_up),
        .pump_dn  (pump_dn),
        .wide_hit (wide_hit)
    );

    pld_period_judge judge_i (
        .clk      (clk),
        .rst      (rst),
        .ref_tick (ref_tick),
        .wide_hit (wide_hit),
        .rep      (rep)
    );

    pld_run_counter #(.GOOD_RUN(GOOD_RUN)) run_i (
        .clk      (clk),
        .rst      (rst),
        .wide_hit (wide_hit),
        .rep      (rep),
        .reach    (reach)
    );

    // Fast clear has priority over slow set
    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else if (wide_hit)
            flag_q <= 1'b0;
        else if (reach)
            flag_q <= 1'b1;
    end

    assign lock_flag = flag_q;

endmodule

// File: rtl/pll_lock_detect_chk.sv
module pll_lock_detect_chk #(
    parameter int unsigned WIDTH_LIMIT = 1,
    parameter int unsigned GOOD_RUN    = 8
) (
    input logic clk,
    input logic rst,
    input logic ref_tick,
    input logic pump_up,
    input logic pump_dn,
    input logic lock_flag
);
    localparam int unsigned AW = $clog2(WIDTH_LIMIT + 2);
    localparam int unsigned TW = $clog2(GOOD_RUN + 2);
    localparam logic [AW-1:0] ALIM = AW'(WIDTH_LIMIT);
    localparam logic [TW-1:0] TNEED = TW'(GOOD_RUN + 1);

    logic          act;
    logic [AW-1:0] act_run;
    logic          wide_seen;
    logic [TW-1:0] ticks_since;
    logic          rst_d;

    assign act       = pump_up | pump_dn;
    assign wide_seen = act && (act_run == ALIM);

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst) begin
            act_run     <= '0;
            ticks_since <= '0;
        end else begin
            if (!act)
                act_run <= '0;
            else if (act_run != ALIM)
                act_run <= act_run + 1'b1;
            if (wide_seen)
                ticks_since <= '0;
            else if (ref_tick && ticks_since != TNEED)
                ticks_since <= ticks_since + 1'b1;
        end
    end

    AST_RESET_LOW: assert property (@(posedge clk)
        rst |=> !lock_flag); // R1

    AST_WIDE_DROPS: assert property (@(posedge clk) disable iff (rst)
        wide_seen |=> !lock_flag); // R3

    AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_flag) |-> $past(ref_tick)); // R8

    AST_FALL_ON_WIDE: assert property (@(posedge clk) disable iff (rst)
        (!rst_d && $fell(lock_flag)) |-> $past(wide_seen)); // R8

    AST_RUN_BEFORE_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_flag) |-> (ticks_since >= TNEED)); // R4

endmodule

bind pll_lock_detect pll_lock_detect_chk #(
    .WIDTH_LIMIT (WIDTH_LIMIT),
    .GOOD_RUN    (GOOD_RUN)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .ref_tick  (ref_tick),
    .pump_up   (pump_up),
    .pump_dn   (pump_dn),
    .lock_flag (lock_flag)
);

// File: tb/pll_lock_detect_tb_top.sv
module pll_lock_detect_tb_top;

    localparam int P    = 12;
    localparam int NVEC = 35;
    // {expected flag after closing tick, dir[1:0] (1 up, 2 down, 3 both), width[1:0]}
    localparam logic [4:0] VEC [NVEC] = '{
        5'b00100, 5'b00101, 5'b01001, 5'b00100, 5'b01101, 5'b00100, 5'b00101, 5'b11001,
        5'b10100, 5'b00110,
        5'b00101, 5'b01001, 5'b00101, 5'b01001, 5'b00101, 5'b01001, 5'b01101, 5'b10101,
        5'b01011,
        5'b00101, 5'b00101, 5'b00101, 5'b00101, 5'b00101, 5'b00101, 5'b00101,
        5'b01110,
        5'b00100, 5'b00100, 5'b00100, 5'b00100, 5'b00100, 5'b00100, 5'b00100,
        5'b11001
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_tick = 1'b0;
    logic pump_up = 1'b0;
    logic pump_dn = 1'b0;
    logic lock_flag;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    pll_lock_detect dut_i (
        .clk       (clk),
        .rst       (rst),
        .ref_tick  (ref_tick),
        .pump_up   (pump_up),
        .pump_dn   (pump_dn),
        .lock_flag (lock_flag)
    );

    task automatic drive(input logic t, input logic u, input logic d);
        ref_tick = t;
        pump_up  = u;
        pump_dn  = d;
        @(negedge clk);
    endtask

    task automatic check(input logic exp, input string tag);
        tests++;
        if (lock_flag !== exp) begin
            fails++;
            $display("FAIL %s: lock_flag=%0b expected %0b", tag, lock_flag, exp);
        end
    endtask

    task automatic clean_periods(input int n);
        for (int k = 0; k < n; k++) begin
            for (int c = 0; c < P - 1; c++) drive(1'b0, c == 3, 1'b0);
            drive(1'b1, 1'b0, 1'b0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic prev_exp;
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b0);
        drive(1'b0, 1'b0, 1'b0);
        rst = 1'b0;
        check(1'b0, "R1 reset state");

        // Arming tick, then the table
        drive(1'b1, 1'b0, 1'b0);
        prev_exp = 1'b0;
        for (int v = 0; v < NVEC; v++) begin
            logic       exp;
            logic [1:0] dir;
            int         w;
            exp = VEC[v][4];
            dir = VEC[v][3:2];
            w   = int'(VEC[v][1:0]);
            for (int c = 0; c < P - 1; c++) begin
                logic on;
                on = (c >= 2) && (c < 2 + w);
                drive(1'b0, on && dir[0], on && dir[1]);
                if (w >= 2 && c == 2) check(prev_exp, "R2 first active cycle");
                if (w >= 2 && c == 3) check(1'b0, "R3 fast clear");
            end
            drive(1'b1, 1'b0, 1'b0);
            if (w >= 2)                 check(exp, "R5 run restart");
            else if (prev_exp && exp)   check(exp, "R9 hold");
            else                        check(exp, "R4 set on eighth tick");
            prev_exp = exp;
        end

        // R2: separated single-cycle up and down stay narrow while locked
        for (int c = 0; c < P - 1; c++) drive(1'b0, c == 2, c == 4);
        drive(1'b1, 1'b0, 1'b0);
        check(1'b1, "R2 separated narrow pulses");
        // R2: up then down back to back is one two-cycle pulse
        drive(1'b0, 1'b1, 1'b0);
        drive(1'b0, 1'b0, 1'b1);
        check(1'b0, "R2 merged up/down pulse");

        // R1: reset while locked
        clean_periods(9);
        check(1'b1, "R1 locked before reset");
        rst = 1'b1;
        drive(1'b0, 1'b0, 1'b0);
        rst = 1'b0;
        check(1'b0, "R1 reset clears flag");

        // R6: the first tick only arms
        clean_periods(8);
        check(1'b0, "R6 eight ticks after reset");
        clean_periods(1);
        check(1'b1, "R6 ninth tick after reset");

        // R7: wide pulse straddling a tick
        for (int c = 0; c < P - 2; c++) drive(1'b0, 1'b0, 1'b0);
        drive(1'b0, 1'b0, 1'b1);
        drive(1'b1, 1'b0, 1'b1);
        check(1'b0, "R7 straddle clears");
        clean_periods(8);
        check(1'b0, "R7 new period dirty");
        clean_periods(1);
        check(1'b1, "R7 set on ninth tick");

        // R8: no rise without a tick
        drive(1'b0, 1'b1, 1'b0);
        drive(1'b0, 1'b1, 1'b0);
        drive(1'b1, 1'b0, 1'b0);
        clean_periods(7);
        repeat (40) drive(1'b0, 1'b0, 1'b0);
        check(1'b0, "R8 no rise inside period");
        drive(1'b1, 1'b0, 1'b0);
        check(1'b1, "R8 rise on tick");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule